// File: doc/BRIEF.md
# Oversampling Accumulate-and-Decimate Stage

This block sits between a fast analog-to-digital converter and a circular sample buffer. The converter delivers 10-bit samples at a high rate, each marked by a one-cycle valid strobe. The block adds a fixed number of consecutive samples into a 16-bit accumulator. When a block of samples is complete, it writes the result into the buffer at the current write index, empties the accumulator and steps the index forward. The buffer is therefore filled at a much lower rate than the converter runs, and each stored word carries more resolution than a single sample.

Two ratios are supported. In the full-sum mode, 64 samples are added and the raw sum is stored. This is the largest count whose worst case still fits in 16 bits, and it turns a 512 kHz input into an 8 kHz stream. In the scaled mode, 16 samples are added and the sum is shifted right by two bits before it is stored. That gives two effective bits beyond a single sample and keeps roughly 31.25 kHz of output from a 500 kHz input.

The mode is taken from the mode input when the first sample of a block arrives, and it holds until that block is written. Reading the buffer and interpolating between its words are handled elsewhere.

Top module: `oversample_decimator`

## Requirements
- R1: While reset is high and in the first cycle after it, `wr_en_o` is 0 and `wr_idx_o` is 0. The first block after reset sums only samples accepted after reset.
- R2: With `mode_i` = 0 (full-sum), every 64 accepted samples produce one write whose `wr_data_o` is their exact unsigned sum.
- R3: With `mode_i` = 1 (scaled), every 16 accepted samples produce one write whose `wr_data_o` is their unsigned sum shifted right by 2, rounded toward zero.
- R4: The sample that completes a block is part of the written sum. The next accepted sample starts a new sum from zero, including when blocks run back to back.
- R5: `wr_en_o` is high for exactly one cycle: the cycle after the clock edge that accepts the completing sample. In that cycle, `wr_addr_o` equals the write index as it stood before the write.
- R6: Each write advances `wr_idx_o` by one, modulo 256, so index 255 is followed by 0. The index does not change at any other time.
- R7: In a cycle where `smp_valid_i` is 0, `smp_i` is ignored and neither the sum, the count nor any output changes.
- R8: `mode_i` is sampled on the first accepted sample of each block. A change to `mode_i` during a block has no effect until the next block begins.
- R9: Sixty-four full-scale samples (1023 each) give `wr_data_o` = 65472 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = add 64 samples and store the raw sum; 1 = add 16 samples and store the sum shifted right by 2 |
| smp_valid_i | input | 1 | Marks `smp_i` as a new sample this cycle |
| smp_i | input | 10 | Unsigned converter sample |
| wr_en_o | output | 1 | Single-cycle buffer write strobe |
| wr_addr_o | output | 8 | Buffer address for the write |
| wr_data_o | output | 16 | Word to be written |
| wr_idx_o | output | 8 | Current write index, the address of the next write |

## Verification
If the sample count is wrong, it shows within one block: a write strobe arrives early or late, and the index drifts from the reference. If the accumulator holds a stale or missing value, the next `wr_data_o` is off by that amount. The error cannot be seen before the block closes, which takes up to 64 accepted samples, so the bench compares every output on every clock against a behavioural model. A mode latched at the wrong moment appears as a wrong block length and a wrong shift in the very next write.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef enum logic {
    MODE_FULL_SUM = 1'b0,
    MODE_SCALED   = 1'b1
  } osd_mode_e;
endpackage

// File: rtl/osd_block_ctrl.sv
module osd_block_ctrl
  import osd_pkg::*;
#(
  parameter int LONG_LOG2  = 6,
  parameter int SHORT_LOG2 = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      smp_valid_i,
  input  osd_mode_e mode_i,
  output logic      blk_last_o,
  output osd_mode_e blk_mode_o
);
  localparam int CNT_W   = LONG_LOG2;
  localparam int LONG_N  = 1 << LONG_LOG2;
  localparam int SHORT_N = 1 << SHORT_LOG2;
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_N - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_N - 1);

  logic [CNT_W-1:0] cnt_q;
  osd_mode_e        blk_mode_q;
  osd_mode_e        eff_mode;
  logic [CNT_W-1:0] last_cnt;

  // The mode is taken from the input only when a block is empty.
  always_comb begin
    eff_mode = (cnt_q == '0) ? mode_i : blk_mode_q;
    last_cnt = (eff_mode == MODE_SCALED) ? SHORT_LAST : LONG_LAST;
  end

  assign blk_last_o = smp_valid_i && (cnt_q == last_cnt);
  assign blk_mode_o = eff_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      blk_mode_q <= MODE_FULL_SUM;
    end else if (smp_valid_i) begin
      blk_mode_q <= eff_mode;
      cnt_q      <= blk_last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R8: once a block has begun, its mode stays fixed
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && cnt_q != '0) |=> $stable(blk_mode_q));

  // R4: count never exceeds the last position of the active block length
  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    (blk_mode_q == MODE_SCALED && cnt_q != '0) |-> (cnt_q <= SHORT_LAST));
endmodule

// File: rtl/osd_accum.sv
module osd_accum #(
  parameter int SMP_W = 10,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             blk_last_i,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   wide_sum;

  assign wide_sum = {1'b0, acc_q} + (ACC_W+1)'(smp_i);
  assign sum_o    = wide_sum[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (smp_valid_i)
      acc_q <= blk_last_i ? '0 : sum_o;
  end

  // R9: the running sum never wraps past the accumulator width
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    smp_valid_i |-> (wide_sum[ACC_W] == 1'b0));

  // R7: an idle cycle leaves the accumulator untouched
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_valid_i |=> $stable(acc_q));
endmodule

// File: rtl/osd_write_port.sv
module osd_write_port
  import osd_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int IDX_W      = 8,
  parameter int EXTRA_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_last_i,
  input  osd_mode_e        blk_mode_i,
  input  logic [ACC_W-1:0] sum_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_addr_o,
  output logic [ACC_W-1:0] wr_data_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  logic [ACC_W-1:0] data_next;

  assign data_next = (blk_mode_i == MODE_SCALED) ? (sum_i >> EXTRA_BITS) : sum_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_idx_o  <= '0;
    end else begin
      wr_en_o <= blk_last_i;
      if (blk_last_i) begin
        wr_addr_o <= wr_idx_o;
        wr_data_o <= data_next;
        wr_idx_o  <= wr_idx_o + 1'b1;
      end
    end
  end

  // R5: write strobe lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  // R6: during a write the index already points one past the written address
  a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_idx_o == IDX_W'(wr_addr_o + 1'b1)));
endmodule

// File: rtl/oversample_decimator.sv
module oversample_decimator
  import osd_pkg::*;
#(
  parameter int SMP_W      = 10,
  parameter int ACC_W      = 16,
  parameter int IDX_W      = 8,
  parameter int LONG_LOG2  = 6,
  parameter int SHORT_LOG2 = 4,
  parameter int EXTRA_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_addr_o,
  output logic [ACC_W-1:0] wr_data_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  logic             blk_last;
  osd_mode_e        blk_mode;
  logic [ACC_W-1:0] sum_w;
  osd_mode_e        mode_in;

  assign mode_in = osd_mode_e'(mode_i);

  osd_block_ctrl #(
    .LONG_LOG2 (LONG_LOG2),
    .SHORT_LOG2(SHORT_LOG2)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .smp_valid_i(smp_valid_i),
    .mode_i     (mode_in),
    .blk_last_o (blk_last),
    .blk_mode_o (blk_mode)
  );

  osd_accum #(
    .SMP_W(SMP_W),
    .ACC_W(ACC_W)
  ) u_acc (
    .clk        (clk),
    .rst        (rst),
    .smp_valid_i(smp_valid_i),
    .smp_i      (smp_i),
    .blk_last_i (blk_last),
    .sum_o      (sum_w)
  );

  osd_write_port #(
    .ACC_W     (ACC_W),
    .IDX_W     (IDX_W),
    .EXTRA_BITS(EXTRA_BITS)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .blk_last_i(blk_last),
    .blk_mode_i(blk_mode),
    .sum_i     (sum_w),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_idx_o  (wr_idx_o)
  );

  // R1: no write strobe in the cycle right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wr_en_o && wr_idx_o == '0));
endmodule

// File: tb/oversample_decimator_tb.sv
module oversample_decimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [9:0]  smp_i = '0;
  logic        wr_en_o;
  logic [7:0]  wr_addr_o;
  logic [15:0] wr_data_o;
  logic [7:0]  wr_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit started = 0;
  bit done = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oversample_decimator u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .smp_valid_i(smp_valid_i),
    .smp_i(smp_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_idx_o(wr_idx_o)
  );

  // Behavioural reference model
  int  q[$];
  bit  m_mode = 0;
  bit  exp_en = 0;
  int  exp_addr = 0;
  int  exp_data = 0;
  int  exp_idx = 0;

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      exp_en = 0; exp_idx = 0; q.delete();
    end else begin
      exp_en = 0;
      if (smp_valid_i) begin
        if (q.size() == 0) m_mode = mode_i;
        q.push_back(int'(smp_i));
        if (q.size() == (m_mode ? 16 : 64)) begin
          int s;
          s = 0;
          foreach (q[k]) s += q[k];
          exp_data = m_mode ? s / 4 : s;
          exp_addr = exp_idx;
          exp_idx  = (exp_idx + 1) % 256;
          exp_en   = 1;
          q.delete();
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5", "wr_en_o", int'(wr_en_o), int'(exp_en));
      chk("R6", "wr_idx_o", int'(wr_idx_o), exp_idx);
      if (exp_en && wr_en_o) begin
        chk("R5", "wr_addr_o", int'(wr_addr_o), exp_addr);
        chk(cur_req, "wr_data_o", int'(wr_data_o), exp_data);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic put(input bit v, input int d);
    @(negedge clk);
    smp_valid_i = v;
    smp_i = 10'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 10'h3ff);
  endtask

  initial begin
    // R1: reset state, with samples offered during reset
    mode_i = 0;
    for (int i = 0; i < 4; i++) put(1, 1000);
    @(negedge clk);
    chk("R1", "wr_en_o in reset", int'(wr_en_o), 0);
    chk("R1", "wr_idx_o in reset", int'(wr_idx_o), 0);
    rst = 0;
    idle(2);

    // R2: full-sum block with a ramp
    cur_req = "R2";
    for (int i = 0; i < 64; i++) put(1, (i * 37) % 1024);
    // R4: back-to-back block, next sum starts from zero
    cur_req = "R4";
    for (int i = 0; i < 64; i++) put(1, (i * 113 + 5) % 1024);
    idle(3);

    // R7: gaps with garbage data while valid is low
    cur_req = "R7";
    for (int i = 0; i < 64; i++) begin
      put(1, (i * 7 + 300) % 1024);
      put(0, 1023 - i);
      if (i % 5 == 0) put(0, 555);
    end
    idle(3);

    // R9: full scale
    cur_req = "R9";
    for (int i = 0; i < 64; i++) put(1, 1023);
    idle(2);

    // R3: scaled mode, several patterns
    cur_req = "R3";
    mode_i = 1;
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 16; i++) put(1, (b * 211 + i * 59 + 3) % 1024);
    for (int i = 0; i < 16; i++) put(1, (i == 0) ? 3 : 0);
    idle(2);

    // R8: mode flips mid-block are ignored
    cur_req = "R8";
    mode_i = 0;
    for (int i = 0; i < 64; i++) begin
      if (i == 10) mode_i = 1;
      if (i == 40) mode_i = 0;
      if (i == 63) mode_i = 1;
      put(1, (i * 19) % 1024);
    end
    for (int i = 0; i < 16; i++) begin
      if (i == 5) mode_i = 0;
      put(1, 900 - i * 11);
    end
    idle(2);

    // R6: enough scaled blocks to wrap the index
    cur_req = "R6";
    mode_i = 1;
    for (int b = 0; b < 260; b++)
      for (int i = 0; i < 16; i++) put(1, (b + i * 61) % 1024);
    idle(4);

    finish_run();
  end
endmodule